// File: doc/BRIEF.md
# Sequential Turn-Signal Lamp Controller

This block drives four three-lamp clusters on a vehicle: front-left, front-right, rear-left and rear-right. The inputs are a left switch, a right switch, a hazard switch and a brake switch. A wide free-running counter turns the fast system clock into a slow step tick. On each tick, every cluster that is active moves one stage through a progressive fill: 000, 001, 011, 111, then back to 000. This gives the sweeping look of a modern indicator.

The switches are arbitrated by fixed priority. The hazard switch makes all four clusters sweep in lockstep and masks both direction switches. The brake switch forces both rear clusters fully lit, whatever the sweep would show. When the left and right switches are on together without hazard, no direction is requested. Whenever the decoded request changes, the sweep restarts at 000 in the same cycle. The counter's terminal count is a parameter. It defaults to the full 45-bit range, and a small value gives short steps in simulation.

Top module: `turn_lamp_ctrl`

## Requirements
- R1: While rst_ni is low, all four lamp buses read 000 at once, whatever the switches are. The divider counter, the step index and the stored request are cleared.
- R2: An active cluster shows 000, 001, 011, 111 in that order, one stage per tick. After 111 it shows 000 on the next tick and keeps cycling while the request stays the same.
- R3: The step tick is high for exactly one cycle every TERM_COUNT+1 clock cycles. The sweep stage changes only on a tick edge or on a request change, so lamp stages last TERM_COUNT+1 cycles.
- R4: With hazard_i high, all four clusters show the same stage every cycle, and turn_left_i and turn_right_i have no effect.
- R5: With brake_i high, both rear buses read 111, overriding any sweep or idle value. The front buses are not affected.
- R6: With only turn_left_i high (no hazard), the front-left and rear-left buses sweep. The front-right bus reads 000, and the rear-right bus reads 000 unless the brake is on.
- R7: With only turn_right_i high (no hazard), the front-right and rear-right buses sweep. The front-left bus reads 000, and the rear-left bus reads 000 unless the brake is on.
- R8: With both turn_left_i and turn_right_i high and hazard_i low, no direction is requested. Both front buses read 000, and so do the rear buses unless the brake is on.
- R9: When the decoded request (none, left, right, hazard) changes, the new active clusters show 000 in that same cycle. The sweep then continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| turn_left_i | input | 1 | Left direction switch |
| turn_right_i | input | 1 | Right direction switch |
| hazard_i | input | 1 | Hazard switch, overrides directions |
| brake_i | input | 1 | Brake switch, lights rear clusters |
| lamp_front_l_o | output | 3 | Front-left cluster fill |
| lamp_front_r_o | output | 3 | Front-right cluster fill |
| lamp_rear_l_o | output | 3 | Rear-left cluster fill |
| lamp_rear_r_o | output | 3 | Rear-right cluster fill |

## Verification
The lamp buses are a combinational function of the registered step state and the live switch levels. A switch change (restart, brake override, masking) is therefore due in the same cycle, and the bench drives inputs on the falling edge and samples one time unit later. A sweep advance is due on the rising edge where the divider sits at its terminal count. The bench keeps its own counter, started from reset release, and compares every bus once per cycle at the following falling edge. In addition, it measures the gap between lamp changes in clock cycles to confirm the TERM_COUNT+1 stage length.

// File: rtl/tsig_pkg.sv
package tsig_pkg;

    localparam int unsigned LAMPS_PER_CLUSTER = 3;
    localparam int unsigned STEP_W            = 2;

    typedef logic [LAMPS_PER_CLUSTER-1:0] lamp_t;
    typedef logic [STEP_W-1:0]            step_t;

    typedef enum logic [1:0] {
        REQ_IDLE   = 2'd0,
        REQ_LEFT   = 2'd1,
        REQ_RIGHT  = 2'd2,
        REQ_HAZARD = 2'd3
    } req_e;

    typedef struct packed {
        lamp_t front_l;
        lamp_t front_r;
        lamp_t rear_l;
        lamp_t rear_r;
    } lamp_bus_t;

    localparam lamp_t LAMP_OFF  = '0;
    localparam lamp_t LAMP_FULL = '1;

    // Thermometer fill: stage s lights the s lowest lamps.
    function automatic lamp_t fill_of(step_t s);
        logic [LAMPS_PER_CLUSTER:0] one_hot;
        one_hot = ({{LAMPS_PER_CLUSTER{1'b0}}, 1'b1} << s);
        return lamp_t'(one_hot - 1'b1);
    endfunction

    // Fixed priority: hazard, then a single direction; both directions cancel.
    function automatic req_e decode_req(logic left, logic right, logic hazard);
        if (hazard)             return REQ_HAZARD;
        else if (left && !right) return REQ_LEFT;
        else if (right && !left) return REQ_RIGHT;
        else                    return REQ_IDLE;
    endfunction

endpackage

// File: rtl/step_divider.sv
module step_divider #(
    parameter int unsigned          CNT_W      = 45,
    parameter logic [CNT_W-1:0]     TERM_COUNT = {CNT_W{1'b1}}
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    logic [CNT_W-1:0] cnt_q;

    assign tick_o = (cnt_q == TERM_COUNT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
    import tsig_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  req_e  req_i,
    input  logic  tick_i,
    output step_t step_o
);
    req_e  held_q;
    step_t step_q;
    logic  restart;

    assign restart = (req_i != held_q);
    assign step_o  = restart ? step_t'(0) : step_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            held_q <= REQ_IDLE;
            step_q <= '0;
        end else begin
            held_q <= req_i;
            if (restart || req_i == REQ_IDLE) step_q <= '0;
            else if (tick_i)                  step_q <= step_q + step_t'(1);
        end
    end
endmodule

// File: rtl/lamp_mux.sv
module lamp_mux
    import tsig_pkg::*;
(
    input  req_e      req_i,
    input  step_t     step_i,
    input  logic      brake_i,
    output lamp_bus_t lamps_o
);
    lamp_t fill;
    logic  left_on, right_on;

    assign fill     = fill_of(step_i);
    assign left_on  = (req_i == REQ_LEFT)  || (req_i == REQ_HAZARD);
    assign right_on = (req_i == REQ_RIGHT) || (req_i == REQ_HAZARD);

    always_comb begin
        lamps_o.front_l = left_on  ? fill : LAMP_OFF;
        lamps_o.front_r = right_on ? fill : LAMP_OFF;
        lamps_o.rear_l  = brake_i ? LAMP_FULL : (left_on  ? fill : LAMP_OFF);
        lamps_o.rear_r  = brake_i ? LAMP_FULL : (right_on ? fill : LAMP_OFF);
    end
endmodule

// File: rtl/turn_lamp_ctrl.sv
module turn_lamp_ctrl
    import tsig_pkg::*;
#(
    parameter int unsigned      CNT_W      = 45,
    parameter logic [CNT_W-1:0] TERM_COUNT = {CNT_W{1'b1}}
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        turn_left_i,
    input  logic        turn_right_i,
    input  logic        hazard_i,
    input  logic        brake_i,
    output logic [2:0]  lamp_front_l_o,
    output logic [2:0]  lamp_front_r_o,
    output logic [2:0]  lamp_rear_l_o,
    output logic [2:0]  lamp_rear_r_o
);
    logic      step_tick;
    req_e      req_cur;
    step_t     step_eff;
    lamp_bus_t lamps;

    assign req_cur = decode_req(turn_left_i, turn_right_i, hazard_i);

    step_divider #(.CNT_W(CNT_W), .TERM_COUNT(TERM_COUNT)) div_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (step_tick)
    );

    sweep_seq seq_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req_cur),
        .tick_i (step_tick),
        .step_o (step_eff)
    );

    lamp_mux mux_i (
        .req_i   (req_cur),
        .step_i  (step_eff),
        .brake_i (brake_i),
        .lamps_o (lamps)
    );

    // Reset blanks every bus, including the brake override.
    assign lamp_front_l_o = rst_ni ? lamps.front_l : LAMP_OFF;
    assign lamp_front_r_o = rst_ni ? lamps.front_r : LAMP_OFF;
    assign lamp_rear_l_o  = rst_ni ? lamps.rear_l  : LAMP_OFF;
    assign lamp_rear_r_o  = rst_ni ? lamps.rear_r  : LAMP_OFF;
endmodule

// File: rtl/turn_lamp_chk.sv
module turn_lamp_chk
    import tsig_pkg::*;
#(
    parameter int unsigned      CNT_W      = 45,
    parameter logic [CNT_W-1:0] TERM_COUNT = {CNT_W{1'b1}}
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       turn_left_i,
    input logic       turn_right_i,
    input logic       hazard_i,
    input logic       brake_i,
    input logic [2:0] fl,
    input logic [2:0] fr,
    input logic [2:0] rl,
    input logic [2:0] rr,
    input logic       tick,
    input req_e       req,
    input step_t      step
);
    function automatic logic legal(logic [2:0] v);
        return v == 3'b000 || v == 3'b001 || v == 3'b011 || v == 3'b111;
    endfunction

    always @(negedge clk_i) begin
        if (!rst_ni)
            assert_reset_dark_R1: assert (fl == 3'b0 && fr == 3'b0 && rl == 3'b0 && rr == 3'b0);
    end

    assert_fill_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        legal(fl) && legal(fr) && legal(rl) && legal(rr));

    assert_tick_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && TERM_COUNT != '0) |=> !tick);

    assert_step_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick |=> (req != $past(req)) || (step == $past(step)));

    assert_hazard_lockstep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hazard_i && !brake_i) |-> (fl == fr && fl == rl && fl == rr));

    assert_brake_rear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brake_i |-> (rl == 3'b111 && rr == 3'b111));

    assert_left_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (turn_left_i && !turn_right_i && !hazard_i) |-> (fr == 3'b0 && (brake_i || rr == 3'b0)));

    assert_right_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (turn_right_i && !turn_left_i && !hazard_i) |-> (fl == 3'b0 && (brake_i || rl == 3'b0)));

    assert_conflict_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (turn_left_i && turn_right_i && !hazard_i) |-> (fl == 3'b0 && fr == 3'b0));

    assert_restart_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req != $past(req)) |-> step == '0);
endmodule

bind turn_lamp_ctrl turn_lamp_chk #(.CNT_W(CNT_W), .TERM_COUNT(TERM_COUNT)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .turn_left_i  (turn_left_i),
    .turn_right_i (turn_right_i),
    .hazard_i     (hazard_i),
    .brake_i      (brake_i),
    .fl           (lamp_front_l_o),
    .fr           (lamp_front_r_o),
    .rl           (lamp_rear_l_o),
    .rr           (lamp_rear_r_o),
    .tick         (step_tick),
    .req          (req_cur),
    .step         (step_eff)
);

// File: tb/turn_lamp_ctrl_tb_top.sv
`timescale 1ns/1ps
module turn_lamp_ctrl_tb_top;
    localparam int unsigned CNT_W  = 45;
    localparam int unsigned TERM   = 7;
    localparam int unsigned PERIOD = TERM + 1;

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic sw_l = 1'b0, sw_r = 1'b0, sw_h = 1'b0, sw_b = 1'b0;
    logic [2:0] fl, fr, rl, rr;

    int checks = 0;
    int failures = 0;

    always #5 clk_i = ~clk_i;

    turn_lamp_ctrl #(.CNT_W(CNT_W), .TERM_COUNT(45'(TERM))) dut_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .turn_left_i    (sw_l),
        .turn_right_i   (sw_r),
        .hazard_i       (sw_h),
        .brake_i        (sw_b),
        .lamp_front_l_o (fl),
        .lamp_front_r_o (fr),
        .lamp_rear_l_o  (rl),
        .lamp_rear_r_o  (rr)
    );

    // Expectation model built from the requirements:
    // request code 0 none, 1 left, 2 right, 3 hazard; stage k lights k lamps.
    int m_cnt, m_stage, m_held;

    function automatic int exp_req();
        if (sw_h)              return 3;
        if (sw_l && !sw_r)     return 1;
        if (sw_r && !sw_l)     return 2;
        return 0;
    endfunction

    function automatic logic [2:0] stage_bits(int k);
        case (k)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    always @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_cnt = 0; m_stage = 0; m_held = 0;
        end else begin
            int rq;
            rq = exp_req();
            if (rq != m_held || rq == 0) m_stage = 0;
            else if (m_cnt == TERM)      m_stage = (m_stage + 1) % 4;
            m_held = rq;
            m_cnt = (m_cnt == TERM) ? 0 : m_cnt + 1;
        end
    end

    task automatic chk(string tag, string what, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cmp_model(string tag);
        int rq, st;
        logic [2:0] f, el, er;
        rq = exp_req();
        st = (rq != m_held) ? 0 : m_stage;
        f  = stage_bits(st);
        el = (rq == 1 || rq == 3) ? f : 3'b000;
        er = (rq == 2 || rq == 3) ? f : 3'b000;
        chk(tag, "front_l", fl, el);
        chk(tag, "front_r", fr, er);
        chk(tag, "rear_l",  rl, sw_b ? 3'b111 : el);
        chk(tag, "rear_r",  rr, sw_b ? 3'b111 : er);
    endtask

    task automatic set_sw(logic l, logic r, logic h, logic b);
        @(negedge clk_i);
        sw_l = l; sw_r = r; sw_h = h; sw_b = b;
        #1;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i); #1;
            cmp_model(tag);
        end
    endtask

    task automatic t_reset();
        @(negedge clk_i);
        rst_ni = 1'b0; sw_l = 1; sw_r = 0; sw_h = 1; sw_b = 1;
        #1;
        chk("R1", "front_l in reset", fl, 3'b000);
        chk("R1", "front_r in reset", fr, 3'b000);
        chk("R1", "rear_l in reset",  rl, 3'b000);
        chk("R1", "rear_r in reset",  rr, 3'b000);
        sw_l = 0; sw_h = 0; sw_b = 0;
        @(negedge clk_i);
        rst_ni = 1'b1;
        #1;
        cmp_model("R1");
    endtask

    task automatic t_left();
        logic saw_full = 1'b0;
        set_sw(1, 0, 0, 0);
        chk("R9", "front_l on start", fl, 3'b000);
        for (int i = 0; i < 5 * PERIOD; i++) begin
            @(negedge clk_i); #1;
            cmp_model("R6");
            if (fl == 3'b111) saw_full = 1'b1;
        end
        chk("R2", "front_l reached full", {2'b0, saw_full}, 3'b001);
        chk("R6", "front_r idle", fr, 3'b000);
    endtask

    task automatic t_right();
        set_sw(0, 1, 0, 0);
        chk("R9", "front_r on start", fr, 3'b000);
        run(5 * PERIOD, "R7");
        chk("R7", "rear_l idle", rl, 3'b000);
    endtask

    task automatic t_hazard();
        set_sw(0, 0, 1, 0);
        run(5 * PERIOD, "R4");
        set_sw(1, 0, 1, 0);   // direction while hazard: no restart, no effect
        cmp_model("R4");
        run(3 * PERIOD, "R4");
        chk("R4", "front_r matches front_l", fr, fl);
    endtask

    task automatic t_brake();
        set_sw(1, 0, 0, 1);
        chk("R5", "rear_l braking", rl, 3'b111);
        chk("R5", "rear_r braking", rr, 3'b111);
        run(3 * PERIOD, "R5");
        set_sw(0, 0, 1, 1);
        run(3 * PERIOD, "R5");
        set_sw(0, 0, 0, 1);
        chk("R5", "front_l brake only", fl, 3'b000);
        run(PERIOD, "R5");
    endtask

    task automatic t_conflict();
        set_sw(1, 1, 0, 0);
        run(3 * PERIOD, "R8");
        chk("R8", "front_l both dirs", fl, 3'b000);
        chk("R8", "front_r both dirs", fr, 3'b000);
    endtask

    task automatic t_change();
        set_sw(1, 0, 0, 0);
        run(2 * PERIOD + 3, "R9");
        set_sw(0, 1, 0, 0);
        chk("R9", "front_l after switch", fl, 3'b000);
        chk("R9", "front_r after switch", fr, 3'b000);
        run(2 * PERIOD, "R9");
        set_sw(0, 0, 1, 0);
        chk("R9", "rear_l on hazard start", rl, 3'b000);
        run(PERIOD, "R9");
    endtask

    task automatic t_period();
        logic [2:0] last;
        int last_change = -1;
        set_sw(0, 0, 0, 0);
        set_sw(1, 0, 0, 0);
        last = fl;
        for (int i = 0; i < 6 * PERIOD; i++) begin
            @(negedge clk_i); #1;
            if (fl != last) begin
                if (last_change >= 0)
                    chk("R3", "stage length", 3'(i - last_change), 3'(PERIOD));
                last_change = i;
                last = fl;
            end
        end
        chk("R3", "changes observed", {2'b0, last_change >= 0}, 3'b001);
    endtask

    initial begin
        #100_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        t_left();
        t_right();
        t_hazard();
        t_brake();
        t_conflict();
        t_change();
        t_period();
        t_reset();
        t_left();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule